// File: doc/BRIEF.md
# Flash Status Auto-Poller

This block waits on a serial flash device without processor involvement. After a start pulse it repeatedly selects the flash and sends a one-byte read-status instruction on four data lines. It then receives one status byte on the same four lines and checks it against a mask and an expected value. Between polls, chip select is released for a programmable number of serial clock periods.

A poll matches when the received byte, ANDed with the mask, equals the expected value. To wait for a bit to become set, the expected value equals the mask. To wait for it to clear, the expected value is zero. Every match sets a sticky flag. The stop-on-match setting decides whether the first match ends the sequence or polling continues. An abort input ends polling at any point. The most recent status byte stays visible on an output.

The serial clock runs at half the system clock. Each serial period is one system cycle with the serial clock low, followed by one cycle with it high. Outgoing nibbles change while the serial clock is low. Incoming nibbles are captured at the system edge that ends the high half.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy is 0, cs_n is 1, sclk is 0, io_oe is 0, match_flag is 0 and status_byte is 0x00.
- R2: Each poll holds cs_n low for exactly 8 system cycles (4 serial periods). In the first two serial periods, io_oe is 1 and io_out carries instruction bits [7:4] and then [3:0]. In the last two, io_oe is 0 and the block receives status bits [7:4] and then [3:0] on io_in. There is no address phase and there are no dummy cycles.
- R3: A poll matches when (byte & mask) == match_val. A match sets match_flag. match_flag stays set until a start is accepted, which clears it.
- R4: With stop_on_match = 1, a matching poll ends the sequence: busy is 0 and cs_n is 1 in the cycle after the last status nibble is captured.
- R5: With stop_on_match = 0, a match sets match_flag but polling continues with the usual gap.
- R6: Between polls, cs_n is 1 and sclk is 0 for 2·max(interval,1) system cycles. An interval of 0 behaves as 1.
- R7: abort = 1 at a clock edge forces busy = 0 and cs_n = 1 from the next cycle. If abort coincides with the capture of the last status nibble, that byte is discarded and match_flag and status_byte keep their values.
- R8: status_byte shows the byte received by the most recently completed poll and changes only when a poll completes.
- R9: A start is accepted only when the block is idle and abort is 0. A start while busy is ignored. instr, mask, match_val, interval and stop_on_match are captured when a start is accepted, and later changes to them have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling sequence |
| abort | input | 1 | Cancel polling |
| instr | input | 8 | Status-read instruction byte |
| mask | input | 8 | Bits of the status byte that are compared |
| match_val | input | 8 | Expected value of the masked bits |
| interval | input | IW | Gap between polls, in serial clock periods |
| stop_on_match | input | 1 | End the sequence at the first match |
| io_in | input | 4 | Data lines from the flash |
| busy | output | 1 | Polling sequence active |
| match_flag | output | 1 | Sticky: some poll has matched |
| status_byte | output | 8 | Last received status byte |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Data lines to the flash |
| io_oe | output | 1 | Output enable for io_out |

## Verification
Two functions can fall in the same cycle: an abort and the capture of the final status nibble. When both happen, the abort wins and the byte is dropped.

The bench provokes this by counting system cycles from an accepted start and raising abort exactly in the eighth cycle of a poll whose byte would match. It judges the result by checking that busy falls and that match_flag and status_byte keep their earlier values. A second collision, a start and an abort at the same edge, is driven while the block is idle and must leave it idle.

// File: rtl/flash_status_poller.sv
module flash_status_poller #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [7:0]    instr,
  input  logic [7:0]    mask,
  input  logic [7:0]    match_val,
  input  logic [IW-1:0] interval,
  input  logic          stop_on_match,
  input  logic [3:0]    io_in,
  output logic          busy,
  output logic          match_flag,
  output logic [7:0]    status_byte,
  output logic          sclk,
  output logic          cs_n,
  output logic [3:0]    io_out,
  output logic          io_oe
);
  localparam int GW = IW + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t           st;
  logic [2:0]    step;
  logic [GW-1:0] gap_cnt;
  logic [7:0]    l_instr, l_mask, l_val;
  logic [IW-1:0] l_iv;
  logic          l_stop;
  logic [3:0]    hi_nib;

  logic [IW-1:0] iv_eff;
  logic [GW-1:0] gap_end;
  logic [7:0]    rx_byte;
  logic          hit;

  assign iv_eff  = (l_iv == '0) ? IW'(1) : l_iv;
  assign gap_end = {iv_eff, 1'b0} - GW'(1);
  assign rx_byte = {hi_nib, io_in};
  assign hit     = ((rx_byte & l_mask) == l_val);

  assign busy   = (st != S_IDLE);
  assign cs_n   = (st != S_XFER);
  assign sclk   = (st == S_XFER) & step[0];
  assign io_oe  = (st == S_XFER) & ~step[2];
  assign io_out = step[1] ? l_instr[3:0] : l_instr[7:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      step        <= '0;
      gap_cnt     <= '0;
      l_instr     <= '0;
      l_mask      <= '0;
      l_val       <= '0;
      l_iv        <= '0;
      l_stop      <= 1'b0;
      hi_nib      <= '0;
      match_flag  <= 1'b0;
      status_byte <= '0;
    end else if (abort) begin
      st   <= S_IDLE;
      step <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st         <= S_XFER;
          step       <= '0;
          l_instr    <= instr;
          l_mask     <= mask;
          l_val      <= match_val;
          l_iv       <= interval;
          l_stop     <= stop_on_match;
          match_flag <= 1'b0;
        end
        S_XFER: begin
          step <= step + 3'd1;
          if (step == 3'd5) hi_nib <= io_in;
          if (step == 3'd7) begin
            status_byte <= rx_byte;
            if (hit) match_flag <= 1'b1;
            st      <= (hit && l_stop) ? S_IDLE : S_GAP;
            gap_cnt <= '0;
          end
        end
        S_GAP: begin
          if (gap_cnt == gap_end) begin
            st   <= S_XFER;
            step <= '0;
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_status_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       abort,
  input logic       busy,
  input logic       match_flag,
  input logic [7:0] status_byte,
  input logic       sclk,
  input logic       cs_n,
  input logic       io_oe
);
  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  assert_oe_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe || sclk) |-> !cs_n);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !start) |=> match_flag);

  assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && cs_n));

  assert_status_at_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_byte) |-> $past(!cs_n));

  assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !abort) |=> busy);
endmodule

bind flash_status_poller flash_status_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy),
  .match_flag(match_flag), .status_byte(status_byte), .sclk(sclk),
  .cs_n(cs_n), .io_oe(io_oe)
);

// File: tb/flash_status_poller_tb_top.sv
module flash_status_poller_tb_top;
  localparam int IW = 8;

  logic clk = 0, rst_n = 0, start = 0, abort = 0, stop_on_match = 0;
  logic [7:0] instr = 8'h05, mask = 0, match_val = 0;
  logic [IW-1:0] interval = 0;
  logic [3:0] io_in = 0;
  logic busy, match_flag, sclk, cs_n, io_oe;
  logic [7:0] status_byte;
  logic [3:0] io_out;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_status_poller #(.IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .instr(instr),
    .mask(mask), .match_val(match_val), .interval(interval),
    .stop_on_match(stop_on_match), .io_in(io_in), .busy(busy),
    .match_flag(match_flag), .status_byte(status_byte), .sclk(sclk),
    .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model
  logic [7:0] flash_status = 0, cur_byte = 0, cap_instr = 0;
  int rc = 0;
  logic prev_sclk = 0;
  always @(negedge clk) begin
    if (cs_n) rc = 0;
    else if (sclk && !prev_sclk) begin
      rc++;
      if (rc == 1) cap_instr[7:4] = io_out;
      if (rc == 2) begin
        cap_instr[3:0] = io_out;
        chk(cap_instr == m_instr, "R2 R9 instruction seen by flash", cap_instr, m_instr);
      end
      if (rc == 3) begin cur_byte = flash_status; io_in = cur_byte[7:4]; end
      if (rc == 4) io_in = cur_byte[3:0];
    end
    prev_sclk = sclk;
  end

  // behavioural reference model
  int m_st = 0, m_t = 0, m_g = 0, polls = 0;
  bit m_flag = 0, m_stop = 0;
  logic [7:0] m_status = 0, m_instr = 0, m_mask = 0, m_val = 0;
  int m_iv = 0;
  always @(posedge clk) begin
    if (!rst_n) begin m_st = 0; m_flag = 0; m_status = 0; m_t = 0; end
    else if (abort) m_st = 0;
    else case (m_st)
      0: if (start) begin
        m_st = 1; m_t = 0; m_flag = 0; m_instr = instr; m_mask = mask;
        m_val = match_val; m_iv = int'(interval); m_stop = stop_on_match;
      end
      1: if (m_t == 7) begin
        polls++;
        m_status = cur_byte;
        if ((cur_byte & m_mask) == m_val) begin
          m_flag = 1;
          if (m_stop) m_st = 0; else begin m_st = 2; m_g = 0; end
        end else begin m_st = 2; m_g = 0; end
      end else m_t++;
      default: if (m_g == 2 * ((m_iv == 0) ? 1 : m_iv) - 1) begin m_st = 1; m_t = 0; end
               else m_g++;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy == (m_st != 0), "R4 R5 R7 R9 busy", busy, m_st != 0);
      chk(cs_n == (m_st != 1), "R2 R6 R7 cs_n", cs_n, m_st != 1);
      chk(sclk == (m_st == 1 && m_t % 2 == 1), "R2 R6 sclk", sclk, m_st == 1 && m_t % 2 == 1);
      chk(io_oe == (m_st == 1 && m_t < 4), "R2 io_oe", io_oe, m_st == 1 && m_t < 4);
      if (io_oe)
        chk(io_out == (m_t < 2 ? m_instr[7:4] : m_instr[3:0]), "R2 io_out", io_out,
            m_t < 2 ? m_instr[7:4] : m_instr[3:0]);
      chk(match_flag == m_flag, "R3 match_flag", match_flag, m_flag);
      chk(status_byte == m_status, "R8 status_byte", status_byte, m_status);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic go(input logic [7:0] mk, input logic [7:0] mv, input int iv, input bit stp);
    mask = mk; match_val = mv; interval = IW'(iv); stop_on_match = stp; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_polls(input int n);
    int target = polls + n;
    while (polls < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && cs_n && !sclk && !io_oe && !match_flag && status_byte == 0,
        "R1 reset state", {busy, cs_n, sclk, io_oe, match_flag}, 5'b01000);
    rst_n = 1;
    @(negedge clk);

    // wait for bit 0 to clear, interval 3
    flash_status = 8'h03;
    go(8'h01, 8'h00, 3, 1);
    wait_polls(2);
    flash_status = 8'h02;
    wait_idle();
    chk(match_flag == 1, "R3 R4 clear-wait matched", match_flag, 1);
    chk(status_byte == 8'h02, "R8 last byte", status_byte, 8'h02);

    // wait for bit 7 to set, interval 0 (minimum gap)
    instr = 8'hA7; flash_status = 8'h11;
    go(8'h80, 8'h80, 0, 1);
    chk(match_flag == 0, "R3 flag cleared by start", match_flag, 0);
    wait_polls(3);
    flash_status = 8'h91;
    wait_idle();
    chk(match_flag == 1 && status_byte == 8'h91, "R3 R6 set-wait", status_byte, 8'h91);

    // continuous polling, no stop
    flash_status = 8'hFF;
    go(8'h0F, 8'h0F, 2, 0);
    wait_polls(3);
    chk(busy == 1 && match_flag == 1, "R5 polling continues after match", busy, 1);
    abort = 1; @(negedge clk); abort = 0;
    chk(busy == 0 && cs_n == 1, "R7 abort stops", busy, 0);

    // abort coinciding with last nibble capture
    flash_status = 8'h3C;
    go(8'hFF, 8'h3C, 1, 1);
    repeat (7) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk(match_flag == 0, "R7 abort discards byte flag", match_flag, 0);
    chk(status_byte == 8'hFF, "R7 abort discards byte status", status_byte, 8'hFF);

    // start while busy ignored, parameters latched
    instr = 8'h70; flash_status = 8'h00;
    go(8'h01, 8'h01, 1, 1);
    repeat (3) @(negedge clk);
    instr = 8'hEE; mask = 8'h00; match_val = 8'h00;
    start = 1; @(negedge clk); start = 0;
    wait_polls(2);
    chk(busy == 1 && match_flag == 0, "R9 latched mask, restart ignored", busy, 1);
    abort = 1; @(negedge clk); abort = 0;

    // start and abort in the same cycle
    start = 1; abort = 1; @(negedge clk); start = 0; abort = 0;
    @(negedge clk);
    chk(busy == 0, "R9 start with abort ignored", busy, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule